// File: doc/BRIEF.md
# MDIO Paged Register Access Bridge

This block sits behind an MDIO management interface (serial framing already decoded) and opens a large paged register space to the host. The space is addressed by an 8-bit page and an 8-bit offset. The host sees only a few 16-bit management registers at one fixed PHY address. The host picks a page, stages up to four 16-bit data words, and writes a command word that carries the target offset and a read or write request. The request bits stay set while the access runs and clear on their own when it finishes. The host polls them to find out when the access is done.

On the far side the bridge drives a simple register-bank port. It presents the page, the offset and a 64-bit write word, pulses a write or read strobe for one cycle, and waits for the bank to signal ready. On a read, the 64-bit word returned by the bank is split across the four data registers, least significant word first. The same data registers carry 8-, 16-, 32- and 48-bit values, each in its low-order bits.

Top module: `mdio_page_bridge`

## Requirements
- R1: The bridge answers only at PHY address 30. A write to any other PHY address changes nothing, and a read there returns 0x0000.
- R2: Register 0x10 holds the page in bits 15:8 and the page-enable flag in bit 0. Reading it returns the last accepted value with bits 7:1 as zero.
- R3: A command written to register 0x11 while page enable is 0 starts no bank access. The offset in bits 15:8 is still stored, and the command bits (1:0) read back as zero.
- R4: A command with bit 0 set (write) produces exactly one cycle of bank_wr, in the cycle after the command is accepted. During that pulse, bank_page and bank_off carry the page and offset, and bank_wdata carries {reg 0x1B, reg 0x1A, reg 0x19, reg 0x18}.
- R5: A command with bit 1 set (read) produces exactly one cycle of bank_rd. When the bank signals ready, bank_rdata bits 15:0, 31:16, 47:32 and 63:48 are stored into registers 0x18, 0x19, 0x1A and 0x1B.
- R6: Register 0x11 bits 1:0 show the requested operation, bit 1 for read and bit 0 for write. They read nonzero from the strobe cycle through the cycle in which bank_ready is high, and read zero from the next cycle on. With the ready pulse N cycles after the strobe, they are set for N+1 cycles.
- R7: While an access is in progress, every management write is ignored: page, offset, command and data registers all keep their values.
- R8: At PHY address 30, writes to any register other than 0x10, 0x11 and 0x18 to 0x1B are ignored, and reads of them return 0x0000.
- R9: A command with both bits 1 and 0 set is carried out as a read only.
- R10: Reads of the data registers while idle return the last value written by the host or loaded by a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mgmt_wr | input | 1 | Management write strobe, one cycle per access |
| mgmt_rd | input | 1 | Management read enable; mgmt_rdata is valid while high |
| mgmt_phy | input | 5 | Management PHY address |
| mgmt_reg | input | 5 | Management register number |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data, combinational from the address |
| bank_page | output | 8 | Page presented to the register bank |
| bank_off | output | 8 | Offset presented to the register bank |
| bank_wdata | output | 64 | Write word for the register bank |
| bank_wr | output | 1 | One-cycle write strobe |
| bank_rd | output | 1 | One-cycle read strobe |
| bank_rdata | input | 64 | Read word returned by the register bank |
| bank_ready | input | 1 | Bank completion pulse |

## Verification
The bench builds the bridge with its default parameters: PHY address 30, four 16-bit data words, and 8-bit page and offset. With these, the full 64-bit staging path and the fixed register numbers are reachable. The bench model of the register bank changes its ready latency at run time, from zero (ready in the same cycle as the strobe) up to eight cycles. This covers both the completion straight out of the strobe cycle and a long busy window in which the host's ignored writes can land.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;

  localparam logic [1:0] OPB_NONE = 2'b00;
  localparam logic [1:0] OPB_WR   = 2'b01;
  localparam logic [1:0] OPB_RD   = 2'b10;

endpackage

// File: rtl/mpb_rst_sync.sv
module mpb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;

endmodule

// File: rtl/mpb_decode.sv
module mpb_decode #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned PHY_ADDR  = 30,
  parameter int unsigned REG_PAGE  = 16,
  parameter int unsigned REG_CMD   = 17,
  parameter int unsigned REG_DATA0 = 24,
  parameter int unsigned NWORDS    = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  output logic              hit_page,
  output logic              hit_cmd,
  output logic              hit_data,
  output logic [NWORDS-1:0] hit_word,
  output logic [IDX_W-1:0]  word_idx
);

  logic phy_ok;

  assign phy_ok   = (phy == ADDR_W'(PHY_ADDR));
  assign hit_page = phy_ok && (regad == ADDR_W'(REG_PAGE));
  assign hit_cmd  = phy_ok && (regad == ADDR_W'(REG_CMD));

  genvar gi;
  generate
    for (gi = 0; gi < NWORDS; gi++) begin : g_word
      assign hit_word[gi] = phy_ok && (regad == ADDR_W'(REG_DATA0 + gi));
    end
  endgenerate

  assign hit_data = |hit_word;

  always_comb begin
    word_idx = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (hit_word[i]) word_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/mpb_regs.sv
module mpb_regs #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NWORDS = 4,
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFF_W  = 8,
  localparam int unsigned DATA_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              hit_page,
  input  logic              hit_cmd,
  input  logic [NWORDS-1:0] hit_word,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ld_rd,
  input  logic [DATA_W-1:0] ld_data,
  output logic [PAGE_W-1:0] pg_q,
  output logic              pg_en_q,
  output logic [OFF_W-1:0]  off_q,
  output logic [DATA_W-1:0] data_q
);

  logic [PAGE_W-1:0] pg_d;
  logic              pg_en_d;
  logic [OFF_W-1:0]  off_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    pg_d    = pg_q;
    pg_en_d = pg_en_q;
    off_d   = off_q;
    data_d  = data_q;
    if (ld_rd) begin
      data_d = ld_data;
    end
    if (we) begin
      if (hit_page) begin
        pg_d    = wdata[WORD_W-1 -: PAGE_W];
        pg_en_d = wdata[0];
      end
      if (hit_cmd) begin
        off_d = wdata[WORD_W-1 -: OFF_W];
      end
      for (int i = 0; i < NWORDS; i++) begin
        if (hit_word[i]) data_d[i*WORD_W +: WORD_W] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q    <= '0;
      pg_en_q <= 1'b0;
      off_q   <= '0;
      data_q  <= '0;
    end else begin
      pg_q    <= pg_d;
      pg_en_q <= pg_en_d;
      off_q   <= off_d;
      data_q  <= data_d;
    end
  end

endmodule

// File: rtl/mpb_seq.sv
module mpb_seq
  import mpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_rd,
  input  logic ready,
  output logic strobe_wr,
  output logic strobe_rd,
  output logic busy,
  output logic op_wr,
  output logic op_rd,
  output logic done_rd
);

  sq_state_t  st_q, st_d;
  logic [1:0] op_q, op_d;

  always_comb begin
    st_d = st_q;
    op_d = op_q;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d = SQ_ISSUE;
          op_d = start_rd ? OPB_RD : OPB_WR;
        end
      end
      SQ_ISSUE: begin
        if (ready) begin
          st_d = SQ_IDLE;
          op_d = OPB_NONE;
        end else begin
          st_d = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (ready) begin
          st_d = SQ_IDLE;
          op_d = OPB_NONE;
        end
      end
      default: begin
        st_d = SQ_IDLE;
        op_d = OPB_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      op_q <= OPB_NONE;
    end else begin
      st_q <= st_d;
      op_q <= op_d;
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign strobe_wr = (st_q == SQ_ISSUE) && op_q[0];
  assign strobe_rd = (st_q == SQ_ISSUE) && op_q[1];
  assign op_wr     = op_q[0];
  assign op_rd     = op_q[1];
  assign done_rd   = busy && ready && op_q[1];

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned PHY_ADDR  = 30,
  parameter int unsigned REG_PAGE  = 16,
  parameter int unsigned REG_CMD   = 17,
  parameter int unsigned REG_DATA0 = 24,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NWORDS    = 4,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned OFF_W     = 8,
  localparam int unsigned DATA_W   = WORD_W * NWORDS,
  localparam int unsigned IDX_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int unsigned PAD_PG   = WORD_W - PAGE_W - 1,
  localparam int unsigned PAD_CMD  = WORD_W - OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_wr,
  input  logic              mgmt_rd,
  input  logic [ADDR_W-1:0] mgmt_phy,
  input  logic [ADDR_W-1:0] mgmt_reg,
  input  logic [WORD_W-1:0] mgmt_wdata,
  output logic [WORD_W-1:0] mgmt_rdata,
  output logic [PAGE_W-1:0] bank_page,
  output logic [OFF_W-1:0]  bank_off,
  output logic [DATA_W-1:0] bank_wdata,
  output logic              bank_wr,
  output logic              bank_rd,
  input  logic [DATA_W-1:0] bank_rdata,
  input  logic              bank_ready
);

  logic              rst_q;
  logic              hit_page, hit_cmd, hit_data;
  logic [NWORDS-1:0] hit_word;
  logic [IDX_W-1:0]  word_idx;
  logic [PAGE_W-1:0] pg_q;
  logic              pg_en;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] data_q;
  logic              seq_busy, op_wr, op_rd, done_rd;
  logic              wr_ok, cmd_start;

  mpb_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q)
  );

  mpb_decode #(
    .ADDR_W   (ADDR_W),
    .PHY_ADDR (PHY_ADDR),
    .REG_PAGE (REG_PAGE),
    .REG_CMD  (REG_CMD),
    .REG_DATA0(REG_DATA0),
    .NWORDS   (NWORDS),
    .IDX_W    (IDX_W)
  ) u_dec (
    .phy      (mgmt_phy),
    .regad    (mgmt_reg),
    .hit_page (hit_page),
    .hit_cmd  (hit_cmd),
    .hit_data (hit_data),
    .hit_word (hit_word),
    .word_idx (word_idx)
  );

  // host writes only land while no bank access is running
  assign wr_ok     = mgmt_wr && !seq_busy;
  assign cmd_start = wr_ok && hit_cmd && pg_en && (|mgmt_wdata[1:0]);

  mpb_regs #(
    .WORD_W (WORD_W),
    .NWORDS (NWORDS),
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_q),
    .we       (wr_ok),
    .hit_page (hit_page),
    .hit_cmd  (hit_cmd),
    .hit_word (hit_word),
    .wdata    (mgmt_wdata),
    .ld_rd    (done_rd),
    .ld_data  (bank_rdata),
    .pg_q     (pg_q),
    .pg_en_q  (pg_en),
    .off_q    (off_q),
    .data_q   (data_q)
  );

  mpb_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_q),
    .start     (cmd_start),
    .start_rd  (mgmt_wdata[1]),
    .ready     (bank_ready),
    .strobe_wr (bank_wr),
    .strobe_rd (bank_rd),
    .busy      (seq_busy),
    .op_wr     (op_wr),
    .op_rd     (op_rd),
    .done_rd   (done_rd)
  );

  assign bank_page  = pg_q;
  assign bank_off   = off_q;
  assign bank_wdata = data_q;

  always_comb begin
    mgmt_rdata = '0;
    if (mgmt_rd) begin
      if (hit_page) begin
        mgmt_rdata = {pg_q, {PAD_PG{1'b0}}, pg_en};
      end else if (hit_cmd) begin
        mgmt_rdata = {off_q, {PAD_CMD{1'b0}}, op_rd, op_wr};
      end else if (hit_data) begin
        mgmt_rdata = data_q[word_idx*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFF_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_wr,
  input logic              bank_rd,
  input logic              bank_ready,
  input logic              busy,
  input logic              page_en,
  input logic [PAGE_W-1:0] bank_page,
  input logic [OFF_W-1:0]  bank_off
);

  a_r4_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> !bank_wr);

  a_r5_single_rd: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd |=> !bank_rd);

  a_r9_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_wr && bank_rd));

  a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr || bank_rd) |-> page_en);

  a_r6_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr || bank_rd) |-> busy);

  a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bank_ready) |=> busy);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bank_ready) |=> !busy);

  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(bank_page) && $stable(bank_off)));

endmodule

bind mdio_page_bridge mpb_checker #(
  .PAGE_W (PAGE_W),
  .OFF_W  (OFF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .bank_wr    (bank_wr),
  .bank_rd    (bank_rd),
  .bank_ready (bank_ready),
  .busy       (seq_busy),
  .page_en    (pg_en),
  .bank_page  (bank_page),
  .bank_off   (bank_off)
);

// File: tb/mdio_page_bridge_bench.sv
module mdio_page_bridge_bench;

  logic        clk;
  logic        rst_n;
  logic        h_wr, h_rd;
  logic [4:0]  h_phy, h_reg;
  logic [15:0] h_wdata;
  logic [15:0] mgmt_rdata;
  logic [7:0]  bank_page, bank_off;
  logic [63:0] bank_wdata, bank_rdata;
  logic        bank_wr, bank_rd, bank_ready;

  int checks = 0;
  int bad    = 0;
  int cyc    = 0;
  int lat    = 0;
  int bcnt   = 0;
  int b_wr_cnt = 0;
  int b_rd_cnt = 0;
  logic [63:0] b_last_wdata;
  logic [15:0] b_last_key;
  logic [63:0] mem [logic [15:0]];

  // reference model state
  logic [7:0]  m_page;
  logic        m_en;
  logic [7:0]  m_off;
  logic [15:0] m_data [4];
  int          m_state;   // 0 idle, 1 strobe cycle, 2 waiting
  int          m_op;      // 0 none, 1 write, 2 read

  mdio_page_bridge u_mdio_page_bridge (
    .clk        (clk),
    .rst_n      (rst_n),
    .mgmt_wr    (h_wr),
    .mgmt_rd    (h_rd),
    .mgmt_phy   (h_phy),
    .mgmt_reg   (h_reg),
    .mgmt_wdata (h_wdata),
    .mgmt_rdata (mgmt_rdata),
    .bank_page  (bank_page),
    .bank_off   (bank_off),
    .bank_wdata (bank_wdata),
    .bank_wr    (bank_wr),
    .bank_rd    (bank_rd),
    .bank_rdata (bank_rdata),
    .bank_ready (bank_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] dflt(input logic [15:0] k);
    return {k, ~k, k ^ 16'h0F0F, 16'hC35A};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  function automatic logic [15:0] model_rd();
    logic [15:0] v;
    v = 16'h0000;
    if (h_rd && h_phy == 5'd30) begin
      if (h_reg == 5'h10) v = {m_page, 7'd0, m_en};
      else if (h_reg == 5'h11) v = {m_off, 6'd0, m_op == 2, m_op == 1};
      else if (h_reg >= 5'h18 && h_reg <= 5'h1B) v = m_data[h_reg - 5'h18];
    end
    return v;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_page = 0; m_en = 0; m_off = 0; m_state = 0; m_op = 0;
      for (int i = 0; i < 4; i++) m_data[i] = 0;
    end else begin
      bit was_busy;
      was_busy = (m_state != 0);
      if (m_state != 0 && bank_ready) begin
        if (m_op == 2) for (int i = 0; i < 4; i++) m_data[i] = bank_rdata[i*16 +: 16];
        m_state = 0; m_op = 0;
      end else if (m_state == 1) begin
        m_state = 2;
      end
      if (!was_busy && h_wr && h_phy == 5'd30) begin
        if (h_reg == 5'h10) begin m_page = h_wdata[15:8]; m_en = h_wdata[0]; end
        else if (h_reg == 5'h11) begin
          m_off = h_wdata[15:8];
          if (m_en && h_wdata[1:0] != 0) begin
            m_state = 1;
            m_op = h_wdata[1] ? 2 : 1;
          end
        end
        else if (h_reg >= 5'h18 && h_reg <= 5'h1B) m_data[h_reg - 5'h18] = h_wdata;
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && cyc > 6) begin
      chk(bank_wr == (m_state == 1 && m_op == 1), "R4 write strobe", 64'(bank_wr), 64'(m_state == 1 && m_op == 1));
      chk(bank_rd == (m_state == 1 && m_op == 2), "R5 read strobe", 64'(bank_rd), 64'(m_state == 1 && m_op == 2));
      if (bank_wr || bank_rd) begin
        chk(bank_page == m_page && bank_off == m_off, "R4 page/offset", {bank_page, bank_off}, {m_page, m_off});
      end
      if (bank_wr) begin
        chk(bank_wdata == {m_data[3], m_data[2], m_data[1], m_data[0]}, "R4 wdata", bank_wdata,
            {m_data[3], m_data[2], m_data[1], m_data[0]});
      end
      chk(mgmt_rdata == model_rd(), "R2 R6 R8 readback", 64'(mgmt_rdata), 64'(model_rd()));
    end
  end

  // register bank model
  always @(negedge clk) begin
    if (!rst_n) begin
      bank_ready = 1'b0;
      bcnt = 0;
    end else begin
      bank_ready = 1'b0;
      if (bank_wr || bank_rd) begin
        b_last_key = {bank_page, bank_off};
        if (bank_wr) begin
          mem[b_last_key] = bank_wdata;
          b_last_wdata = bank_wdata;
          b_wr_cnt++;
        end else begin
          bank_rdata = mem.exists(b_last_key) ? mem[b_last_key] : dflt(b_last_key);
          b_rd_cnt++;
        end
        if (lat == 0) bank_ready = 1'b1;
        else bcnt = lat;
      end else if (bcnt > 0) begin
        bcnt--;
        if (bcnt == 0) bank_ready = 1'b1;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      chk(1'b0, "R6 watchdog expired", 64'(cyc), 64'd50000);
      summary();
      $finish;
    end
  end

  task automatic hwr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    @(negedge clk);
    h_wr = 1'b1; h_phy = phy; h_reg = rg; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic hrd(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] exp, input string tag);
    @(negedge clk);
    h_rd = 1'b1; h_phy = phy; h_reg = rg;
    @(posedge clk);
    #5;
    chk(mgmt_rdata == exp, tag, 64'(mgmt_rdata), 64'(exp));
    @(negedge clk);
    h_rd = 1'b0;
  endtask

  task automatic count_busy(input int expn, input string tag);
    int n;
    n = 0;
    h_rd = 1'b1; h_phy = 5'd30; h_reg = 5'h11;
    #1;
    while (mgmt_rdata[1:0] != 2'b00 && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
    h_rd = 1'b0;
    chk(n == expn, tag, 64'(n), 64'(expn));
  endtask

  initial begin
    int wc, rc;
    rst_n = 1'b0;
    h_wr = 0; h_rd = 0; h_phy = 0; h_reg = 0; h_wdata = 0;
    bank_rdata = 0; bank_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    hrd(30, 5'h10, 16'h0000, "R2 reset page");
    hrd(30, 5'h11, 16'h0000, "R6 reset cmd");
    hrd(30, 5'h18, 16'h0000, "R10 reset data");

    // R2 page register
    hwr(30, 5'h10, 16'h3401);
    hrd(30, 5'h10, 16'h3401, "R2 page readback");
    hwr(30, 5'h10, 16'hABFF);
    hrd(30, 5'h10, 16'hAB01, "R2 low bits masked");

    // R1 foreign PHY address
    hwr(5, 5'h10, 16'h5501);
    hrd(30, 5'h10, 16'hAB01, "R1 foreign write ignored");
    hrd(5, 5'h10, 16'h0000, "R1 foreign read zero");

    // R8 unmapped register
    hwr(30, 5'h12, 16'hFFFF);
    hrd(30, 5'h12, 16'h0000, "R8 unmapped reads zero");
    hrd(30, 5'h10, 16'hAB01, "R8 unmapped write no effect");

    // R3 command without page enable
    wc = b_wr_cnt;
    hwr(30, 5'h10, 16'h2200);
    hwr(30, 5'h11, 16'h4001);
    repeat (4) @(negedge clk);
    chk(b_wr_cnt == wc, "R3 no strobe", 64'(b_wr_cnt), 64'(wc));
    hrd(30, 5'h11, 16'h4000, "R3 bits zero offset kept");

    // R4 write access, R10 data staging
    hwr(30, 5'h10, 16'h1201);
    hwr(30, 5'h18, 16'h1111);
    hwr(30, 5'h19, 16'h2222);
    hwr(30, 5'h1A, 16'h3333);
    hwr(30, 5'h1B, 16'h4444);
    hrd(30, 5'h19, 16'h2222, "R10 data readback");
    lat = 8;
    wc = b_wr_cnt;
    hwr(30, 5'h11, 16'h5A01);
    // R7 writes while busy
    hwr(30, 5'h11, 16'h7702);
    hwr(30, 5'h18, 16'hDEAD);
    hwr(30, 5'h10, 16'h9901);
    repeat (10) @(negedge clk);
    chk(b_wr_cnt == wc + 1, "R4 one write", 64'(b_wr_cnt), 64'(wc + 1));
    chk(b_last_wdata == 64'h4444_3333_2222_1111, "R4 word order", b_last_wdata, 64'h4444_3333_2222_1111);
    chk(b_last_key == 16'h125A, "R4 page offset", 64'(b_last_key), 64'h125A);
    hrd(30, 5'h11, 16'h5A00, "R7 cmd unchanged");
    hrd(30, 5'h18, 16'h1111, "R7 data unchanged");
    hrd(30, 5'h10, 16'h1201, "R7 page unchanged");

    // R5 read access with ready in the strobe cycle
    for (int i = 0; i < 4; i++) hwr(30, 5'(5'h18 + i), 16'h0000);
    lat = 0;
    rc = b_rd_cnt;
    hwr(30, 5'h11, 16'h5A02);
    repeat (3) @(negedge clk);
    chk(b_rd_cnt == rc + 1, "R5 one read", 64'(b_rd_cnt), 64'(rc + 1));
    hrd(30, 5'h18, 16'h1111, "R5 word0");
    hrd(30, 5'h19, 16'h2222, "R5 word1");
    hrd(30, 5'h1A, 16'h3333, "R5 word2");
    hrd(30, 5'h1B, 16'h4444, "R5 word3");

    // R9 both bits set
    lat = 2;
    wc = b_wr_cnt;
    rc = b_rd_cnt;
    hwr(30, 5'h11, 16'h6003);
    repeat (5) @(negedge clk);
    chk(b_wr_cnt == wc && b_rd_cnt == rc + 1, "R9 read only", 64'({b_wr_cnt[15:0], b_rd_cnt[15:0]}),
        64'({wc[15:0], 16'(rc + 1)}));
    hrd(30, 5'h18, 16'hC35A, "R9 word0");
    hrd(30, 5'h1B, 16'h1260, "R9 word3");
    hrd(30, 5'h1A, 16'hED9F, "R9 word2");

    // R6 busy window length
    lat = 5;
    hwr(30, 5'h11, 16'h3001);
    count_busy(6, "R6 busy cycles lat5");
    lat = 0;
    hwr(30, 5'h11, 16'h3102);
    count_busy(1, "R6 busy cycles lat0");
    hrd(30, 5'h11, 16'h3100, "R6 bits cleared");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule